// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control sequencer of a 16-bit real-mode processor core. On a typed software interrupt, a breakpoint, or an overflow trap whose condition holds, it saves the flags, code segment and instruction pointer on the stack. It clears the trap and interrupt-enable bits. It then reads the four-byte vector for the interrupt type and returns the new CS:IP. On a return request it pops IP, CS and flags from the stack. It also sets or clears the interrupt-enable bit.

The core presents its current SS, SP, CS, IP and flags with a one-cycle request. The sequencer captures them and runs word-wide transactions on a valid/ready memory port. It reports the new SP, CS, IP and flags with a one-cycle done pulse. Physical addresses are segment times 16 plus offset, modulo 2^20. Opcodes: 0 typed interrupt, 1 breakpoint, 2 overflow trap, 3 return, 4 set interrupt-enable, 5 clear interrupt-enable.

Top module: `intr_seq`

## Requirements
- R1: The vector of type t sits at byte address 4*t (always below 1024). The new IP is read from 4*t and the new CS from 4*t+2.
- R2: Entry runs these transactions in this order: write flags to SP-2, write CS to SP-4, read the CS vector word, write IP to SP-6, read the IP vector word. SP leaves 6 lower, and each push decrements SP by 2 before its write.
- R3: After entry, flags_o equals the captured flags with bit 9 (interrupt enable) and bit 8 (trap) cleared. The pushed copy keeps both bits.
- R4: Return (op 3) reads IP at SP, CS at SP+2 and flags at SP+4, in that order. It loads all 16 flag bits and leaves SP 6 higher.
- R5: Op 0 uses req_type_i as the vector type. Op 1 always uses type 3 and ignores req_type_i.
- R6: Op 2 with flag bit 11 (overflow) set enters through type 4. With bit 11 clear it makes no memory transaction and returns SP, CS, IP and flags unchanged.
- R7: Op 4 sets flag bit 9 and op 5 clears it. All other bits pass through and no memory transaction occurs.
- R8: mem_valid_o, once raised, holds with stable address, write flag and write data until mem_ready_i. Each transaction moves one word.
- R9: A request made while busy_o is high is ignored, as are ops 6 and 7. An ignored request gives no done pulse and no memory transaction.
- R10: done_o is a one-cycle pulse in the cycle after the final register load. For ops without memory traffic, that is the cycle after acceptance.
- R11: After reset, busy_o, done_o and mem_valid_o are low and SP, CS, IP and flags outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 3 | Operation code |
| req_type_i | input | 8 | Interrupt type for op 0 |
| ss_i | input | 16 | Current stack segment |
| sp_i | input | 16 | Current stack pointer |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer (return address) |
| flags_i | input | 16 | Current flags |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Results valid, one-cycle pulse |
| sp_o | output | 16 | New stack pointer |
| cs_o | output | 16 | New code segment |
| ip_o | output | 16 | New instruction pointer |
| flags_o | output | 16 | New flags |
| mem_valid_o | output | 1 | Memory transaction request |
| mem_write_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 20 | Physical byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Transaction completes this cycle |
| mem_rdata_i | input | 16 | Read data, valid with ready |

## Verification
A wrong state step shows up in the transaction log as a missing, extra or reordered access. It also shows up as a stack address off by a word, visible at the very handshake where it occurs. A wrong flag mask or vector offset appears on flags_o, cs_o or ip_o at the done pulse, at most six handshakes after the request. A stuck busy state or a lost done shows within a few cycles, as a missing pulse or as requests that are not accepted.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [2:0] {
    OP_INT   = 3'd0,
    OP_BRK   = 3'd1,
    OP_OVF   = 3'd2,
    OP_RET   = 3'd3,
    OP_SETIE = 3'd4,
    OP_CLRIE = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PSH_FL, ST_PSH_CS, ST_RD_CS, ST_PSH_IP, ST_RD_IP,
    ST_POP_IP, ST_POP_CS, ST_POP_FL, ST_DONE
  } state_e;
endpackage

// File: rtl/intr_seq_vec.sv
module intr_seq_vec #(
  parameter int TYPE_W    = 8,
  parameter int ADDR_W    = 20,
  parameter int VEC_SHIFT = 2
) (
  input  logic [TYPE_W-1:0] type_i,
  output logic [ADDR_W-1:0] ip_addr_o,
  output logic [ADDR_W-1:0] cs_addr_o
);
  localparam int PAD = ADDR_W - TYPE_W - VEC_SHIFT;

  assign ip_addr_o = {{PAD{1'b0}}, type_i, {VEC_SHIFT{1'b0}}};
  assign cs_addr_o = ip_addr_o + ADDR_W'(2);
endmodule

// File: rtl/intr_seq_stk.sv
module intr_seq_stk #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [DATA_W-1:0] ss_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [ADDR_W-1:0] pop_addr_o
);
  localparam int WORD_B = DATA_W / 8;

  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] sp_dec;

  assign base        = ADDR_W'({ss_i, {SEG_SHIFT{1'b0}}});
  assign sp_dec      = sp_i - DATA_W'(WORD_B);
  assign push_addr_o = base + ADDR_W'(sp_dec);
  assign pop_addr_o  = base + ADDR_W'(sp_i);
endmodule

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int TYPE_W    = 8,
  parameter int VEC_SHIFT = 2,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int OF_BIT    = 11,
  parameter int BRK_TYPE  = 3,
  parameter int OVF_TYPE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [TYPE_W-1:0] req_type_i,
  input  logic [DATA_W-1:0] ss_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] cs_i,
  input  logic [DATA_W-1:0] ip_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [ADDR_W-1:0] vec_ip_addr_i,
  input  logic [ADDR_W-1:0] vec_cs_addr_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [ADDR_W-1:0] pop_addr_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [TYPE_W-1:0] type_o,
  output logic [DATA_W-1:0] ss_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] ip_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int WORD_B    = DATA_W / 8;
  localparam int VEC_LIMIT = (1 << TYPE_W) << VEC_SHIFT;

  state_e            state;
  logic [TYPE_W-1:0] type_r;
  logic [DATA_W-1:0] ss_r, sp_r, cs_r, ip_r, flags_r;

  state_e            start_st;
  logic [TYPE_W-1:0] start_type;
  logic [DATA_W-1:0] start_flags;
  logic              op_ok, accept, hs;

  always_comb begin
    op_ok       = 1'b1;
    start_st    = ST_DONE;
    start_type  = req_type_i;
    start_flags = flags_i;
    case (req_op_i)
      OP_INT:   start_st = ST_PSH_FL;
      OP_BRK: begin
        start_st   = ST_PSH_FL;
        start_type = TYPE_W'(BRK_TYPE);
      end
      OP_OVF: begin
        start_st   = flags_i[OF_BIT] ? ST_PSH_FL : ST_DONE;
        start_type = TYPE_W'(OVF_TYPE);
      end
      OP_RET:   start_st = ST_POP_IP;
      OP_SETIE: start_flags[IF_BIT] = 1'b1;
      OP_CLRIE: start_flags[IF_BIT] = 1'b0;
      default:  op_ok = 1'b0;
    endcase
  end

  assign accept = req_valid_i && (state == ST_IDLE) && op_ok;
  assign hs     = mem_valid_o && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      type_r  <= '0;
      ss_r    <= '0;
      sp_r    <= '0;
      cs_r    <= '0;
      ip_r    <= '0;
      flags_r <= '0;
    end else if (accept) begin
      state   <= start_st;
      type_r  <= start_type;
      ss_r    <= ss_i;
      sp_r    <= sp_i;
      cs_r    <= cs_i;
      ip_r    <= ip_i;
      flags_r <= start_flags;
    end else begin
      case (state)
        ST_PSH_FL: if (hs) begin
          sp_r            <= sp_r - DATA_W'(WORD_B);
          flags_r[IF_BIT] <= 1'b0;
          flags_r[TF_BIT] <= 1'b0;
          state           <= ST_PSH_CS;
        end
        ST_PSH_CS: if (hs) begin
          sp_r  <= sp_r - DATA_W'(WORD_B);
          state <= ST_RD_CS;
        end
        ST_RD_CS: if (hs) begin
          cs_r  <= mem_rdata_i;
          state <= ST_PSH_IP;
        end
        ST_PSH_IP: if (hs) begin
          sp_r  <= sp_r - DATA_W'(WORD_B);
          state <= ST_RD_IP;
        end
        ST_RD_IP: if (hs) begin
          ip_r  <= mem_rdata_i;
          state <= ST_DONE;
        end
        ST_POP_IP: if (hs) begin
          ip_r  <= mem_rdata_i;
          sp_r  <= sp_r + DATA_W'(WORD_B);
          state <= ST_POP_CS;
        end
        ST_POP_CS: if (hs) begin
          cs_r  <= mem_rdata_i;
          sp_r  <= sp_r + DATA_W'(WORD_B);
          state <= ST_POP_FL;
        end
        ST_POP_FL: if (hs) begin
          flags_r <= mem_rdata_i;
          sp_r    <= sp_r + DATA_W'(WORD_B);
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid_o = 1'b1;
    mem_write_o = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state)
      ST_PSH_FL: begin mem_write_o = 1'b1; mem_addr_o = push_addr_i; mem_wdata_o = flags_r; end
      ST_PSH_CS: begin mem_write_o = 1'b1; mem_addr_o = push_addr_i; mem_wdata_o = cs_r;    end
      ST_PSH_IP: begin mem_write_o = 1'b1; mem_addr_o = push_addr_i; mem_wdata_o = ip_r;    end
      ST_RD_CS:  mem_addr_o = vec_cs_addr_i;
      ST_RD_IP:  mem_addr_o = vec_ip_addr_i;
      ST_POP_IP, ST_POP_CS, ST_POP_FL: mem_addr_o = pop_addr_i;
      default:   mem_valid_o = 1'b0;
    endcase
  end

  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_DONE);
  assign type_o  = type_r;
  assign ss_o    = ss_r;
  assign sp_o    = sp_r;
  assign cs_o    = cs_r;
  assign ip_o    = ip_r;
  assign flags_o = flags_r;

  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R1
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && (state == ST_RD_CS || state == ST_RD_IP)
      |-> !mem_write_o && (mem_addr_o < ADDR_W'(VEC_LIMIT)));

  // R2
  sp_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && mem_write_o |=> sp_r == $past(sp_r) - DATA_W'(WORD_B));

  // R3
  flags_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_PSH_CS |-> !flags_r[IF_BIT] && !flags_r[TF_BIT]);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_valid_i |=> $stable(type_r) && $stable(ss_r));
endmodule

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int TYPE_W    = 8,
  parameter int VEC_SHIFT = 2,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [TYPE_W-1:0] req_type_i,
  input  logic [DATA_W-1:0] ss_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] cs_i,
  input  logic [DATA_W-1:0] ip_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] cs_o,
  output logic [DATA_W-1:0] ip_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [TYPE_W-1:0] type_w;
  logic [DATA_W-1:0] ss_w;
  logic [ADDR_W-1:0] vec_ip_addr, vec_cs_addr, push_addr, pop_addr;

  intr_seq_vec #(.TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .VEC_SHIFT(VEC_SHIFT)) i_vec (
    .type_i    (type_w),
    .ip_addr_o (vec_ip_addr),
    .cs_addr_o (vec_cs_addr)
  );

  intr_seq_stk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) i_stk (
    .ss_i        (ss_w),
    .sp_i        (sp_o),
    .push_addr_o (push_addr),
    .pop_addr_o  (pop_addr)
  );

  intr_seq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W),
                  .VEC_SHIFT(VEC_SHIFT)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_op_i      (req_op_i),
    .req_type_i    (req_type_i),
    .ss_i          (ss_i),
    .sp_i          (sp_i),
    .cs_i          (cs_i),
    .ip_i          (ip_i),
    .flags_i       (flags_i),
    .vec_ip_addr_i (vec_ip_addr),
    .vec_cs_addr_i (vec_cs_addr),
    .push_addr_i   (push_addr),
    .pop_addr_i    (pop_addr),
    .mem_ready_i   (mem_ready_i),
    .mem_rdata_i   (mem_rdata_i),
    .type_o        (type_w),
    .ss_o          (ss_w),
    .sp_o          (sp_o),
    .cs_o          (cs_o),
    .ip_o          (ip_o),
    .flags_o       (flags_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .mem_valid_o   (mem_valid_o),
    .mem_write_o   (mem_write_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o)
  );
endmodule

// File: tb/test_intr_seq.sv
`timescale 1ns/1ps
module test_intr_seq;
  localparam logic [15:0] SS = 16'h0020;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  typ;
    logic [15:0] flg;
    logic [15:0] sp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h10, 16'h0302, 16'h0600},
    '{3'd0, 8'd100, 16'h0202, 16'h0500},
    '{3'd0, 8'hFF, 16'h0002, 16'h0400},
    '{3'd0, 8'h00, 16'h0100, 16'h0480},
    '{3'd1, 8'h55, 16'h0200, 16'h0420},
    '{3'd2, 8'h77, 16'h0800, 16'h0440},
    '{3'd2, 8'h77, 16'h0200, 16'h0440},
    '{3'd4, 8'h00, 16'h0000, 16'h0300},
    '{3'd5, 8'h00, 16'h0FFF, 16'h0300},
    '{3'd3, 8'h00, 16'h0000, 16'h0380},
    '{3'd3, 8'h00, 16'hFFFF, 16'h0700}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_type = '0;
  logic [15:0] sp_in = '0, cs_in = '0, ip_in = '0, fl_in = '0;
  logic busy, done, mem_valid, mem_write, mem_ready = 1'b0;
  logic [15:0] sp_out, cs_out, ip_out, fl_out, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;

  logic [15:0] mem [0:2047];
  logic [19:0] log_a [0:7];
  logic        log_w [0:7];
  logic [15:0] log_d [0:7];
  int log_n = 0, cyc = 0, last_hs = 0, done_cnt = 0;
  int checks = 0, failures = 0;
  logic [1:0] stall = '0;

  always #2 clk = ~clk;

  intr_seq i_intr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_type_i(req_type), .ss_i(SS), .sp_i(sp_in), .cs_i(cs_in), .ip_i(ip_in),
    .flags_i(fl_in), .busy_o(busy), .done_o(done), .sp_o(sp_out), .cs_o(cs_out),
    .ip_o(ip_out), .flags_o(fl_out), .mem_valid_o(mem_valid), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[11:1]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_valid && mem_ready) begin
      if (mem_write) mem[mem_addr[11:1]] <= mem_wdata;
      if (log_n < 8) begin
        log_a[log_n] <= mem_addr;
        log_w[log_n] <= mem_write;
        log_d[log_n] <= mem_wdata;
      end
      log_n   <= log_n + 1;
      last_hs <= cyc;
    end
  end

  always @(negedge clk) begin
    stall     <= stall + 2'd1;
    mem_ready <= (stall != 2'd0);
  end

  function automatic logic [19:0] ph(input logic [15:0] sp);
    return {SS, 4'b0} + 20'(sp);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag, input int k, input logic [19:0] a,
                         input logic w, input logic [15:0] d);
    chk({tag, " addr"}, 32'(log_a[k]), 32'(a));
    chk({tag, " dir"}, 32'(log_w[k]), 32'(w));
    if (w) chk({tag, " data"}, 32'(log_d[k]), 32'(d));
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] typ, input logic [15:0] flg,
                        input logic [15:0] sp, input logic [15:0] cs, input logic [15:0] ip,
                        input bit preload);
    logic [7:0] t;
    logic entry, ret;
    logic [15:0] e_ip, e_cs, e_fl, e_sp;
    int n;
    t     = (op == 3'd1) ? 8'd3 : (op == 3'd2) ? 8'd4 : typ;
    entry = (op == 3'd0) || (op == 3'd1) || (op == 3'd2 && flg[11]);
    ret   = (op == 3'd3);
    if (ret && preload) begin
      mem[ph(sp) >> 1]               = 16'h3000 ^ sp;
      mem[ph(sp + 16'd2) >> 1]       = 16'h4000 ^ sp;
      mem[ph(sp + 16'd4) >> 1]       = 16'h0B55 ^ sp;
    end
    if (entry) begin
      e_ip = 16'h1000 + 16'(t); e_cs = 16'hC000 + 16'(t);
      e_fl = flg & 16'hFCFF;    e_sp = sp - 16'd6;
    end else if (ret) begin
      e_ip = mem[ph(sp) >> 1]; e_cs = mem[ph(sp + 16'd2) >> 1];
      e_fl = mem[ph(sp + 16'd4) >> 1]; e_sp = sp + 16'd6;
    end else begin
      e_ip = ip; e_cs = cs; e_sp = sp; e_fl = flg;
      if (op == 3'd4) e_fl[9] = 1'b1;
      if (op == 3'd5) e_fl[9] = 1'b0;
    end
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_op = op; req_type = typ;
    sp_in = sp; cs_in = cs; ip_in = ip; fl_in = flg;
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end while (!done && n < 200);
    chk("R10 done seen", 32'(done), 32'd1);
    chk("R1 R5 ip_o", 32'(ip_out), 32'(e_ip));
    chk("R1 R5 cs_o", 32'(cs_out), 32'(e_cs));
    chk("R2 R4 sp_o", 32'(sp_out), 32'(e_sp));
    chk("R3 R4 R7 flags_o", 32'(fl_out), 32'(e_fl));
    if (entry) begin
      chk("R2 count", 32'(log_n), 32'd5);
      chk_log("R2 push flags", 0, ph(sp - 16'd2), 1'b1, flg);
      chk_log("R2 push cs", 1, ph(sp - 16'd4), 1'b1, cs);
      chk_log("R1 read cs vec", 2, 20'(t) * 20'd4 + 20'd2, 1'b0, '0);
      chk_log("R2 push ip", 3, ph(sp - 16'd6), 1'b1, ip);
      chk_log("R1 read ip vec", 4, 20'(t) * 20'd4, 1'b0, '0);
      chk("R10 done after last load", 32'(cyc - last_hs), 32'd1);
    end else if (ret) begin
      chk("R4 count", 32'(log_n), 32'd3);
      chk_log("R4 pop ip", 0, ph(sp), 1'b0, '0);
      chk_log("R4 pop cs", 1, ph(sp + 16'd2), 1'b0, '0);
      chk_log("R4 pop flags", 2, ph(sp + 16'd4), 1'b0, '0);
      chk("R10 done after last load", 32'(cyc - last_hs), 32'd1);
    end else begin
      chk("R6 R7 no memory", 32'(log_n), 32'd0);
      chk("R10 done next cycle", 32'(n), 32'd1);
    end
    @(negedge clk);
    chk("R10 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int dc;
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    for (int i = 0; i < 256; i++) begin
      mem[i * 2]     = 16'h1000 + 16'(i);
      mem[i * 2 + 1] = 16'hC000 + 16'(i);
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 mem_valid", 32'(mem_valid), 32'd0);
    chk("R11 regs", {sp_out, cs_out | ip_out | fl_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].op, VECS[i].typ, VECS[i].flg, VECS[i].sp,
             16'h7000 + 16'(i), 16'h0100 + 16'(i * 3), 1'b1);

    // R4 round trip: return restores the state an entry saved
    run_op(3'd0, 8'h21, 16'h0B02, 16'h0600, 16'h1234, 16'h5678, 1'b0);
    run_op(3'd3, 8'h00, 16'h0000, 16'h05FA, 16'hEEEE, 16'hDDDD, 1'b0);
    chk("R4 round ip", 32'(ip_out), 32'h5678);
    chk("R4 round cs", 32'(cs_out), 32'h1234);
    chk("R4 round flags", 32'(fl_out), 32'h0B02);
    chk("R4 round sp", 32'(sp_out), 32'h0600);

    // R9 request held during a busy entry is ignored
    @(negedge clk);
    log_n = 0;
    dc = done_cnt;
    req_valid = 1'b1; req_op = 3'd0; req_type = 8'h30;
    sp_in = 16'h0500; cs_in = 16'h0AAA; ip_in = 16'h0BBB; fl_in = 16'h0200;
    @(negedge clk);
    req_op = 3'd3;
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 busy ip", 32'(ip_out), 32'h1030);
    chk("R9 busy sp", 32'(sp_out), 32'h04FA);
    chk("R9 busy txns", 32'(log_n), 32'd5);
    chk("R9 busy done count", 32'(done_cnt - dc), 32'd1);

    // R9 undefined ops are ignored
    for (int op = 6; op < 8; op++) begin
      log_n = 0;
      dc = done_cnt;
      req_valid = 1'b1; req_op = 3'(op);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 undefined op done", 32'(done_cnt - dc), 32'd0);
      chk("R9 undefined op txns", 32'(log_n), 32'd0);
      chk("R9 undefined op outputs", 32'(ip_out), 32'h1030);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule